// File: doc/BRIEF.md
# Byte-Lane System Configuration Register Bank

This block is the configuration register file of a peripheral I/O controller, seen from its host bus as a 256-byte window. Inside, every register is reached one byte at a time. Single-byte registers, 16-bit and 32-bit registers stored as little-endian byte lanes, and three-entry byte arrays all share one byte-wide storage path. A host access of one, two or four bytes is accepted in one cycle. It is then carried out as a run of byte cycles on ascending offsets, and a one-cycle acknowledge ends it.

Two offsets return a fixed revision code and cannot be written. Offsets that hold no register read as zero and ignore writes. Any access that touches such an offset, or that tries to write the revision code, raises an error pulse together with the acknowledge. All stored bytes are also brought out on a flat vector, so that the rest of the chip can use the configuration values directly.

Top module: `scr_bank`

## Requirements
- R1: After a synchronous active-low reset, every stored byte is zero, and `ack`, `err` and `busy` are low.
- R2: A read of offset 0x08 returns the revision value 3, and a read of offset 0x09 returns 0. A write to either offset changes no state and raises `err`.
- R3: The single-byte registers at 0x50, 0x52, 0x54, 0xA0, 0xA1, 0xE0, 0xFC and 0xFF each read back the last value written to them.
- R4: The three-entry arrays based at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88 occupy base, base+1 and base+2, and each entry is written and read on its own.
- R5: The 16-bit registers at 0x60, 0x8C, 0x90, 0x98, 0x9A and 0xE4 and the 32-bit register at 0x9C keep their bytes little-endian, with the low byte at the base offset. A byte write to one lane changes only that lane.
- R6: A read of any other offset returns zero, and a write to it leaves all stored state unchanged.
- R7: `err` is high for exactly the one cycle in which `ack` is high, and only when at least one byte of the access was unmapped or was a write to 0x08 or 0x09.
- R8: The `size` code selects the access width: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. Byte i of the access uses offset (addr+i) mod 256. For a read, `rdata` bits 8i+7:8i carry that byte, and the lanes beyond the width read as zero.
- R9: For a write, the byte in `wdata` bits 8i+7:8i goes to offset (addr+i) mod 256, in ascending order.
- R10: An access of n bytes accepted at a rising edge raises `ack` after the n-th edge, counting the accepting edge as the first. A one-byte read is therefore valid in the cycle after the request. `busy` is high in between, and `req` is ignored while `busy` is high.
- R11: `cfg_bytes` holds the stored register bytes and changes only as the result of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, taken when `busy` is low |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access width code (0 byte, 1 two bytes, 2/3 four bytes) |
| addr | input | 8 | Byte offset from the device base |
| wdata | input | 32 | Write data, low byte first |
| rdata | output | 32 | Read data, valid while `ack` is high |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unmapped or read-only access, high with `ack` |
| busy | output | 1 | Multi-byte access in progress |
| cfg_bytes | output | 360 | All 45 stored register bytes, flattened |

## Verification
The assertions assume that the host keeps its request fields meaningful whenever `req` is high, and that reset is held for at least one edge before traffic starts. The bench drives every input on the falling clock edge and holds a request for a single cycle at a time, so an access is accepted exactly once. The one exception is a deliberate test that keeps `req` high while `busy` is set, to show that the request is ignored. Sweeps cover every offset in all three widths, including wrap-around past 0xFF. In those sweeps the assertion that `cfg_bytes` holds still sees only idle cycles or accepted accesses.

// File: rtl/scr_pkg.sv
// Shared constants and types for the configuration register bank.
// Assumes the register map is fixed at elaboration. Each region is a base
// offset plus a length in bytes, and regions never overlap.
package scr_pkg;

    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int DATA_W = LANES * BYTE_W;
    localparam int NREG   = 22;

    localparam logic [ADDR_W-1:0] REG_BASE [NREG] = '{
        8'h50, 8'h52, 8'h54, 8'hA0, 8'hA1, 8'hE0, 8'hFC, 8'hFF,
        8'h60, 8'h8C, 8'h90, 8'h98, 8'h9A, 8'hE4,
        8'h9C,
        8'h64, 8'h68, 8'h6C, 8'h70, 8'h80, 8'h84, 8'h88
    };

    localparam int REG_LEN [NREG] = '{
        1, 1, 1, 1, 1, 1, 1, 1,
        2, 2, 2, 2, 2, 2,
        4,
        3, 3, 3, 3, 3, 3, 3
    };

    localparam logic [ADDR_W-1:0] REV_OFS = 8'h08;

    // Sum of all region lengths gives the number of storage bytes.
    function automatic int total_slots();
        int s;
        s = 0;
        for (int i = 0; i < NREG; i++) s += REG_LEN[i];
        return s;
    endfunction

    localparam int NSLOT  = total_slots();
    localparam int SLOT_W = $clog2(NSLOT);

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
        logic              rev_lo;
        logic              rev_hi;
    } dec_t;

endpackage

// File: rtl/scr_decode.sv
// Offset decoder. Maps a byte offset to a storage slot, or flags one of the
// two revision offsets. Purely combinational. Assumes that the regions in
// scr_pkg do not overlap, so at most one of them matches.
module scr_decode
    import scr_pkg::*;
(
    input  logic [ADDR_W-1:0] ofs,
    output dec_t              dec
);

    // Scan every region and give the matching one its running slot index.
    always_comb begin
        int start;
        int d;
        dec   = '0;
        start = 0;
        for (int i = 0; i < NREG; i++) begin
            d = int'(ofs) - int'(REG_BASE[i]);
            if (d >= 0 && d < REG_LEN[i]) begin
                dec.hit  = 1'b1;
                dec.slot = SLOT_W'(start + d);
            end
            start += REG_LEN[i];
        end
        dec.rev_lo = (ofs == REV_OFS);
        dec.rev_hi = (ofs == REV_OFS + 8'd1);
    end

endmodule

// File: rtl/scr_store.sv
// Byte storage for all configuration registers. One byte is written per
// cycle, and one byte is read per cycle through a combinational read port.
// Assumes that the write slot is in range whenever wr_en is high.
module scr_store
    import scr_pkg::*;
#(
    parameter int SLOTS = NSLOT,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SW-1:0]           wr_slot,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [SW-1:0]           rd_slot,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [SLOTS*BYTE_W-1:0] flat
);

    logic [BYTE_W-1:0] mem [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Hold one register byte, updated only when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_slot == SW'(g))
                mem[g] <= wr_data;
        end
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    // Select the byte addressed by the read slot.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++)
            if (rd_slot == SW'(i)) rd_data = mem[i];
    end

endmodule

// File: rtl/scr_seq.sv
// Access sequencer. Accepts a one-, two- or four-byte request and issues
// it as byte cycles on ascending offsets. The first byte cycle runs on the
// accepting edge. Read bytes are gathered into lanes, and the per-byte
// error indications are ORed. Assumes that b_rdata and b_bad answer the
// byte address combinationally.
module scr_seq
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              b_act,
    output logic              b_wr,
    output logic [ADDR_W-1:0] b_addr,
    output logic [BYTE_W-1:0] b_wdata,
    input  logic [BYTE_W-1:0] b_rdata,
    input  logic              b_bad,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err,
    output logic              busy
);

    logic              busy_q, we_q, errsum_q, ack_q, err_q;
    logic [LANE_W-1:0] idx_q, last_q, cur_idx, req_last;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wd_q, rdata_q, cur_wd;
    logic              accept;

    assign accept = req && !busy_q;

    // Turn the size code into the index of the final byte lane.
    always_comb begin
        if (size[1])      req_last = LANE_W'(LANES - 1);
        else if (size[0]) req_last = LANE_W'(1);
        else              req_last = '0;
    end

    // Choose between the live request (first byte) and the latched request.
    always_comb begin
        cur_idx = busy_q ? idx_q : '0;
        cur_wd  = busy_q ? wd_q : wdata;
        b_act   = accept || busy_q;
        b_wr    = busy_q ? we_q : we;
        b_addr  = (busy_q ? base_q : addr) + ADDR_W'(cur_idx);
        b_wdata = cur_wd[cur_idx*BYTE_W +: BYTE_W];
    end

    // Step through the byte cycles and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            we_q     <= 1'b0;
            errsum_q <= 1'b0;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            idx_q    <= '0;
            last_q   <= '0;
            base_q   <= '0;
            wd_q     <= '0;
            rdata_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            if (accept) begin
                base_q  <= addr;
                we_q    <= we;
                wd_q    <= wdata;
                rdata_q <= DATA_W'(b_rdata);
                if (req_last == '0) begin
                    ack_q <= 1'b1;
                    err_q <= b_bad;
                end else begin
                    busy_q   <= 1'b1;
                    idx_q    <= LANE_W'(1);
                    last_q   <= req_last;
                    errsum_q <= b_bad;
                end
            end else if (busy_q) begin
                rdata_q[idx_q*BYTE_W +: BYTE_W] <= b_rdata;
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                    ack_q  <= 1'b1;
                    err_q  <= errsum_q || b_bad;
                end else begin
                    idx_q    <= idx_q + LANE_W'(1);
                    errsum_q <= errsum_q || b_bad;
                end
            end
        end
    end

    assign rdata = rdata_q;
    assign ack   = ack_q;
    assign err   = err_q;
    assign busy  = busy_q;

endmodule

// File: rtl/scr_bank.sv
// Top level of the configuration register bank. Joins the sequencer, the
// offset decoder and the byte storage, and supplies the read-only revision
// code. Assumes a 256-byte window and one byte cycle per clock.
module scr_bank
    import scr_pkg::*;
#(
    parameter logic [7:0] REV_LO = 8'd3,
    parameter logic [7:0] REV_HI = 8'd0,
    localparam int CFG_W = NSLOT * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err,
    output logic              busy,
    output logic [CFG_W-1:0]  cfg_bytes
);

    logic              b_act, b_wr, b_bad;
    logic [ADDR_W-1:0] b_addr;
    logic [BYTE_W-1:0] b_wdata, b_rdata, st_rdata;
    dec_t              dec;

    scr_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .size    (size),
        .addr    (addr),
        .wdata   (wdata),
        .b_act   (b_act),
        .b_wr    (b_wr),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata),
        .b_bad   (b_bad),
        .rdata   (rdata),
        .ack     (ack),
        .err     (err),
        .busy    (busy)
    );

    scr_decode u_dec (
        .ofs (b_addr),
        .dec (dec)
    );

    scr_store #(.SLOTS(NSLOT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (b_act && b_wr && dec.hit),
        .wr_slot (dec.slot),
        .wr_data (b_wdata),
        .rd_slot (dec.slot),
        .rd_data (st_rdata),
        .flat    (cfg_bytes)
    );

    // Read byte mux and per-byte error: storage, revision code, or zero.
    always_comb begin
        if (dec.hit)         b_rdata = st_rdata;
        else if (dec.rev_lo) b_rdata = REV_LO;
        else if (dec.rev_hi) b_rdata = REV_HI;
        else                 b_rdata = '0;
        b_bad = !dec.hit && !((dec.rev_lo || dec.rev_hi) && !b_wr);
    end

endmodule

// File: rtl/scr_bank_chk.sv
// Protocol checker for scr_bank, attached by bind. Assumes a synchronous
// active-low reset that is held for at least one edge.
module scr_bank_chk
    import scr_pkg::*;
#(
    parameter int CFG_W = NSLOT * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             we,
    input logic [1:0]       size,
    input logic             ack,
    input logic             err,
    input logic             busy,
    input logic [CFG_W-1:0] cfg_bytes
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_bytes == '0 && !ack && !err && !busy)); // R1

    AST_ERR_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack); // R7

    AST_BYTE_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && size == 2'd0) |=> (ack && !busy)); // R10

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack); // R10

    AST_CFG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req && we)) |=> $stable(cfg_bytes)); // R11

endmodule

bind scr_bank scr_bank_chk #(.CFG_W(scr_pkg::NSLOT * scr_pkg::BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .size      (size),
    .ack       (ack),
    .err       (err),
    .busy      (busy),
    .cfg_bytes (cfg_bytes)
);

// File: tb/scr_bank_test.sv
`timescale 1ns/1ps
module scr_bank_test;
    import scr_pkg::*;

    localparam int CFG_W = NSLOT * BYTE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic             we = 1'b0;
    logic [1:0]       size = 2'd0;
    logic [7:0]       addr = 8'd0;
    logic [31:0]      wdata = 32'd0;
    logic [31:0]      rdata;
    logic             ack, err, busy;
    logic [CFG_W-1:0] cfg_bytes;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    logic [7:0] m [256];

    always #2 clk = ~clk;

    scr_bank uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack), .err(err),
        .busy(busy), .cfg_bytes(cfg_bytes)
    );

    function automatic bit is_store(input int o);
        int b1 [8]  = '{'h50, 'h52, 'h54, 'hA0, 'hA1, 'hE0, 'hFC, 'hFF};
        int b2 [6]  = '{'h60, 'h8C, 'h90, 'h98, 'h9A, 'hE4};
        int b3 [7]  = '{'h64, 'h68, 'h6C, 'h70, 'h80, 'h84, 'h88};
        foreach (b1[i]) if (o == b1[i]) return 1'b1;
        foreach (b2[i]) if (o >= b2[i] && o < b2[i] + 2) return 1'b1;
        foreach (b3[i]) if (o >= b3[i] && o < b3[i] + 3) return 1'b1;
        return (o >= 'h9C && o <= 'h9F);
    endfunction

    function automatic logic [7:0] rd_exp(input int o);
        if (is_store(o)) return m[o];
        if (o == 8) return 8'd3;
        return 8'd0;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return sz[1] ? 4 : (sz[0] ? 2 : 1);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One access: drive at a falling edge, then wait for ack at falling edges.
    task automatic xfer(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic e, output int cyc);
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        cyc = 1;
        while (!ack && cyc < 16) begin
            @(negedge clk);
            cyc++;
        end
        rd = rdata;
        e  = err;
    endtask

    // Model-checked access covering R2, R6, R7, R8, R9 and R10.
    task automatic access(input bit w, input logic [1:0] sz, input int a,
                          input logic [31:0] d, input string rq);
        logic [31:0] rd, exp;
        logic        e;
        bit          exp_e;
        int          cyc, n, o;
        n = nbytes(sz);
        exp = '0;
        exp_e = 1'b0;
        for (int i = 0; i < n; i++) begin
            o = (a + i) % 256;
            if (!is_store(o) && !((o == 8 || o == 9) && !w)) exp_e = 1'b1;
            if (!w) exp[i*8 +: 8] = rd_exp(o);
        end
        xfer(w, sz, 8'(a), d, rd, e, cyc);
        if (w) begin
            for (int i = 0; i < n; i++) begin
                o = (a + i) % 256;
                if (is_store(o)) m[o] = d[i*8 +: 8];
            end
        end else begin
            chk(rd == exp, {rq, " R8 rdata"}, rd, exp);
        end
        chk(e == exp_e, {rq, " R7 err"}, 32'(e), 32'(exp_e));
        chk(cyc == n, {rq, " R10 latency"}, 32'(cyc), 32'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] snap;
        logic [31:0] rd;
        logic        e;
        int          cyc;
        for (int i = 0; i < 256; i++) m[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_bytes == '0, "R1 cfg_bytes", 32'(cfg_bytes[31:0]), 32'd0);
        chk(!ack && !err && !busy, "R1 outputs", {29'd0, ack, err, busy}, 32'd0);

        // R2, R6: byte reads of every offset after reset
        for (int o = 0; o < 256; o++) access(1'b0, 2'd0, o, 32'd0, "sweep0 R2 R6");

        // R3, R4, R5, R6: byte writes of every offset; unmapped ones change nothing
        for (int o = 0; o < 256; o++) begin
            snap = cfg_bytes;
            access(1'b1, 2'd0, o, 32'((o * 37 + 91) & 8'hFF), "wsweep");
            if (!is_store(o))
                chk(cfg_bytes == snap, "R6 unmapped write state", 32'(o), 32'(o));
        end
        for (int o = 0; o < 256; o++) access(1'b0, 2'd0, o, 32'd0, "rsweep R3 R4 R5");

        // R5: single lane updates of multi-byte registers
        access(1'b1, 2'd0, 'h99, 32'h000000C3, "R5 lane");
        access(1'b0, 2'd1, 'h98, 32'd0, "R5 half");
        access(1'b1, 2'd0, 'h9E, 32'h0000005A, "R5 lane32");
        access(1'b0, 2'd2, 'h9C, 32'd0, "R5 word");
        access(1'b1, 2'd1, 'hE4, 32'hBEEF, "R9 half write");
        access(1'b0, 2'd0, 'hE4, 32'd0, "R9 low");
        access(1'b0, 2'd0, 'hE5, 32'd0, "R9 high");

        // R9: four-byte writes across the window, including wrap at 0xFF
        for (int o = 0; o < 256; o += 3)
            access(1'b1, 2'd2, o, {8'(o), 8'(o ^ 8'hA5), 8'(o + 7), 8'(~o)}, "R9 wsweep");

        // R8: reads of every width at every offset
        for (int o = 0; o < 256; o++) access(1'b0, 2'd1, o, 32'd0, "R8 half");
        for (int o = 0; o < 256; o++) access(1'b0, 2'd2, o, 32'd0, "R8 word");
        access(1'b0, 2'd3, 'h9C, 32'd0, "R8 size3");
        access(1'b0, 2'd2, 'hFE, 32'd0, "R8 wrap");

        // R2: a write to the revision code is rejected and leaves it intact
        access(1'b1, 2'd1, 'h08, 32'hFFFF, "R2 write");
        access(1'b0, 2'd1, 'h08, 32'd0, "R2 read");

        // R10: req held high during busy is not taken
        @(negedge clk);
        req = 1'b1; we = 1'b0; size = 2'd2; addr = 8'h9C; wdata = '0;
        @(negedge clk);
        we = 1'b1; size = 2'd0; addr = 8'h50; wdata = 32'h000000AA;
        cyc = 1;
        while (!ack && cyc < 16) begin
            @(negedge clk);
            cyc++;
        end
        req = 1'b0;
        chk(cyc == 4, "R10 busy window", 32'(cyc), 32'd4);
        @(negedge clk);
        chk(!ack, "R10 no extra ack", 32'(ack), 32'd0);
        access(1'b0, 2'd0, 'h50, 32'd0, "R10 req ignored");

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule